// File: doc/BRIEF.md
# Bus Activity Monitor with Consecutive-Period Watermarks

This block watches a bus through per-channel activity strobes and turns them into a per-period load figure. Each channel adds a programmable weight to an accumulator for every strobe. At the end of every sampling period, it folds the accumulated count into an exponential moving average. The sampling period is a programmable number of 1 ms ticks. The raw count is compared against an upper and a lower band. Only a run of N back-to-back periods outside the band raises an event, with N programmed separately for each side. The freshly updated average is compared against its own pair of watermarks.

Software programs the block through a flat 32-bit register port with combinational reads. It receives a single level interrupt and finds the source through a global status word. Two channels are instantiated. Address bits [7:6] select the space: 0 is global, 1 is channel 0 and 2 is channel 1. Word offsets inside a channel:

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | count weight |
| 0x08 | initial average |
| 0x0C | raw upper watermark |
| 0x10 | raw lower watermark |
| 0x14 | average upper watermark |
| 0x18 | average lower watermark |
| 0x1C | interrupt status |
| 0x20 | average (read only) |

The global space has a status word at 0x00 and the period register at 0x04. Addresses whose two low bits are not zero are ignored.

Top module: `busmon_wm`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: While a channel is active, each strobe adds the count weight to its accumulator. At a period end the accumulator restarts. A strobe in that same cycle counts toward the new period.
- R3: A period ends on the (P+1)-th tick, where P is the period register value. The average changes only at a period end.
- R4: At a period end the average becomes avg + ((count − avg) >>> (K+1)), computed in signed arithmetic with floor rounding. K is control bits [12:10].
- R5: A write to control that sets bit 31 while it was clear loads the initial-average value into the average register.
- R6: With control bit 30 set, status bit 31 sets once the count is strictly above the raw upper watermark for N = ctrl[28:26]+1 consecutive periods. The run restarts after it fires, after an in-band period, and while bit 30 is clear.
- R7: With control bit 29 set, status bit 30 sets once the count is strictly below the raw lower watermark for N = ctrl[25:23]+1 consecutive periods. The run restarts under the same rules as R6.
- R8: At a period end, status bit 29 sets if the new average is strictly above the average upper watermark. Status bit 28 sets if it is strictly below the average lower watermark.
- R9: Writing the status register clears every bit written as one. A bit set by a period end in the same cycle stays set.
- R10: Interrupt enables are: status bit 31 by ctrl bit 30, bit 30 by ctrl bit 29, bit 29 by ctrl bit 21, and bit 28 by ctrl bit 20. A channel requests when any enabled status bit is set. Channel 0 shows its request in global status bit 26 and channel 1 in bit 25. `irq_o` is the OR of the requests.
- R11: A channel is active only with control bit 31 (enable) and bit 18 (periodic) both set. An inactive channel ignores strobes and period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| evt_i | input | NCH | Activity strobe, one bit per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
An activity strobe and a period end can fall in the same cycle. The bench provokes this by raising a strobe together with the tick that closes a period. It then judges the result from the averages of that period and the next: the closing period must see a count of zero, and the following one must see exactly one weight. A status clear and a fresh status set can also coincide. The bench judges the clear path with a partial clear that must leave the other pending bit in place.

// File: rtl/busmon_pkg.sv
package busmon_pkg;
  localparam int DW          = 32;
  // control word fields
  localparam int CTL_K_LSB   = 10;
  localparam int CTL_K_W     = 3;
  localparam int CTL_PERIOD  = 18;
  localparam int CTL_ALO_EN  = 20;
  localparam int CTL_AHI_EN  = 21;
  localparam int CTL_NLO_LSB = 23;
  localparam int CTL_NHI_LSB = 26;
  localparam int CTL_N_W     = 3;
  localparam int CTL_CLO_EN  = 29;
  localparam int CTL_CHI_EN  = 30;
  localparam int CTL_EN      = 31;
  // status bits
  localparam int ST_CHI      = 31;
  localparam int ST_CLO      = 30;
  localparam int ST_AHI      = 29;
  localparam int ST_ALO      = 28;
  // global status: channel c at bit GLB_IRQ_TOP - c
  localparam int GLB_IRQ_TOP = 26;

  typedef enum logic [3:0] {
    OFS_CTRL = 4'd0, OFS_WEIGHT = 4'd1, OFS_INIT = 4'd2, OFS_HI = 4'd3,
    OFS_LO   = 4'd4, OFS_AHI    = 4'd5, OFS_ALO  = 4'd6, OFS_STAT = 4'd7,
    OFS_AVG  = 4'd8
  } ofs_e;

  localparam logic [3:0] GLB_STATUS = 4'd0;
  localparam logic [3:0] GLB_PERIOD = 4'd1;
endpackage

// File: rtl/busmon_tick_div.sv
module busmon_tick_div #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [PER_W-1:0] per_i,
  output logic             pend_o
);
  logic [PER_W-1:0] cnt_q;

  assign pend_o = tick_i && (cnt_q >= per_i);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= pend_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/busmon_chan.sv
module busmon_chan
  import busmon_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,
  input  logic          pend_i,
  input  logic          wr_i,
  input  logic [3:0]    idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] avg_o,
  output logic [DW-1:0] stat_o,
  output logic          irq_o
);
  logic [DW-1:0] ctrl_q, wgt_q, init_q, hi_q, lo_q, ahi_q, alo_q, stat_q, avg_q, acc_q;
  logic [CTL_N_W-1:0] chi_q, clo_q;
  logic          active, ld_avg, upd, above, below, chi_fire, clo_fire;
  logic [3:0]    shamt;
  logic signed [DW:0] diff, step;
  logic [DW-1:0] avg_new, set_v, mask_v;

  assign active = ctrl_q[CTL_EN] && ctrl_q[CTL_PERIOD];
  assign upd    = pend_i && active;
  assign ld_avg = wr_i && (idx_i == OFS_CTRL) && wdata_i[CTL_EN] && !ctrl_q[CTL_EN];

  // moving average, signed floor shift
  assign shamt   = {1'b0, ctrl_q[CTL_K_LSB +: CTL_K_W]} + 4'd1;
  assign diff    = $signed({1'b0, acc_q}) - $signed({1'b0, avg_q});
  assign step    = diff >>> shamt;
  assign avg_new = avg_q + step[DW-1:0];

  assign above    = acc_q > hi_q;
  assign below    = acc_q < lo_q;
  assign chi_fire = upd && ctrl_q[CTL_CHI_EN] && above && (chi_q == ctrl_q[CTL_NHI_LSB +: CTL_N_W]);
  assign clo_fire = upd && ctrl_q[CTL_CLO_EN] && below && (clo_q == ctrl_q[CTL_NLO_LSB +: CTL_N_W]);

  always_comb begin
    set_v         = '0;
    set_v[ST_CHI] = chi_fire;
    set_v[ST_CLO] = clo_fire;
    set_v[ST_AHI] = upd && (avg_new > ahi_q);
    set_v[ST_ALO] = upd && (avg_new < alo_q);
    mask_v         = '0;
    mask_v[ST_CHI] = ctrl_q[CTL_CHI_EN];
    mask_v[ST_CLO] = ctrl_q[CTL_CLO_EN];
    mask_v[ST_AHI] = ctrl_q[CTL_AHI_EN];
    mask_v[ST_ALO] = ctrl_q[CTL_ALO_EN];
  end

  // programmable registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; wgt_q <= '0; init_q <= '0; hi_q <= '0;
      lo_q   <= '0; ahi_q <= '0; alo_q  <= '0;
    end else if (wr_i) begin
      case (idx_i)
        OFS_CTRL:   ctrl_q <= wdata_i;
        OFS_WEIGHT: wgt_q  <= wdata_i;
        OFS_INIT:   init_q <= wdata_i;
        OFS_HI:     hi_q   <= wdata_i;
        OFS_LO:     lo_q   <= wdata_i;
        OFS_AHI:    ahi_q  <= wdata_i;
        OFS_ALO:    alo_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // accumulator, average, run counters, status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0; avg_q <= '0; stat_q <= '0; chi_q <= '0; clo_q <= '0;
    end else begin
      if (!active)     acc_q <= '0;
      else if (pend_i) acc_q <= evt_i ? wgt_q : '0;
      else if (evt_i)  acc_q <= acc_q + wgt_q;

      if (ld_avg)   avg_q <= init_q;
      else if (upd) avg_q <= avg_new;

      if (!active || !ctrl_q[CTL_CHI_EN]) chi_q <= '0;
      else if (upd) chi_q <= (above && !chi_fire) ? chi_q + 1'b1 : '0;

      if (!active || !ctrl_q[CTL_CLO_EN]) clo_q <= '0;
      else if (upd) clo_q <= (below && !clo_fire) ? clo_q + 1'b1 : '0;

      stat_q <= ((wr_i && idx_i == OFS_STAT) ? (stat_q & ~wdata_i) : stat_q) | set_v;
    end
  end

  always_comb begin
    case (idx_i)
      OFS_CTRL:   rdata_o = ctrl_q;
      OFS_WEIGHT: rdata_o = wgt_q;
      OFS_INIT:   rdata_o = init_q;
      OFS_HI:     rdata_o = hi_q;
      OFS_LO:     rdata_o = lo_q;
      OFS_AHI:    rdata_o = ahi_q;
      OFS_ALO:    rdata_o = alo_q;
      default:    rdata_o = '0;
    endcase
  end

  assign avg_o  = avg_q;
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_v);
endmodule

// File: rtl/busmon_wm.sv
module busmon_wm
  import busmon_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8,
  parameter int PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms_i,
  input  logic [NCH-1:0]    evt_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  localparam int SEL_LSB = 6;
  localparam int SEL_W   = ADDR_W - SEL_LSB;

  logic [SEL_W-1:0] sel;
  logic [3:0]       widx;
  logic             aligned, glb_wr, period_end;
  logic [PER_W-1:0] per_q;
  logic [DW-1:0]    glb_stat;
  logic [NCH-1:0][DW-1:0] avg_all, stat_all, ch_rdata;
  logic [NCH-1:0]   ch_irq;

  assign sel     = reg_addr_i[ADDR_W-1:SEL_LSB];
  assign widx    = reg_addr_i[SEL_LSB-1:2];
  assign aligned = (reg_addr_i[1:0] == 2'b00);
  assign glb_wr  = reg_wr_i && aligned && (sel == '0) && (widx == GLB_PERIOD);

  always_ff @(posedge clk) begin
    if (!rst_n)      per_q <= '0;
    else if (glb_wr) per_q <= reg_wdata_i[PER_W-1:0];
  end

  busmon_tick_div #(.PER_W(PER_W)) i_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_ms_i), .per_i(per_q), .pend_o(period_end)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    busmon_chan i_chan (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i[c]), .pend_i(period_end),
      .wr_i(reg_wr_i && aligned && (sel == SEL_W'(c + 1))),
      .idx_i(widx), .wdata_i(reg_wdata_i), .rdata_o(ch_rdata[c]),
      .avg_o(avg_all[c]), .stat_o(stat_all[c]), .irq_o(ch_irq[c])
    );
  end

  always_comb begin
    glb_stat = '0;
    for (int c = 0; c < NCH; c++) glb_stat[GLB_IRQ_TOP - c] = ch_irq[c];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (aligned) begin
      if (sel == '0) begin
        if (widx == GLB_STATUS)      reg_rdata_o = glb_stat;
        else if (widx == GLB_PERIOD) reg_rdata_o = DW'(per_q);
      end
      for (int c = 0; c < NCH; c++) begin
        if (sel == SEL_W'(c + 1)) begin
          if (widx == OFS_AVG)       reg_rdata_o = avg_all[c];
          else if (widx == OFS_STAT) reg_rdata_o = stat_all[c];
          else                       reg_rdata_o = ch_rdata[c];
        end
      end
    end
  end

  assign irq_o = |ch_irq;
endmodule

// File: rtl/busmon_wm_chk.sv
module busmon_wm_chk
  import busmon_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_ms_i,
  input logic                   reg_wr_i,
  input logic [ADDR_W-1:0]      reg_addr_i,
  input logic [DW-1:0]          reg_wdata_i,
  input logic                   irq_o,
  input logic                   period_end,
  input logic [NCH-1:0][DW-1:0] avg_all,
  input logic [NCH-1:0][DW-1:0] stat_all
);
  localparam logic [ADDR_W-1:0] CH0_STAT = ADDR_W'((1 << 6) | (int'(OFS_STAT) << 2));

  assert_period_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> tick_ms_i);

  assert_avg_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !reg_wr_i) |=> $stable(avg_all));

  assert_chi_at_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> !$rose(stat_all[0][ST_CHI]));

  assert_clo_at_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> !$rose(stat_all[0][ST_CLO]));

  assert_full_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == CH0_STAT && reg_wdata_i == '1 && !period_end)
      |=> (stat_all[0] == '0));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_all != '0));
endmodule

bind busmon_wm busmon_wm_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms_i(tick_ms_i), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .irq_o(irq_o),
  .period_end(period_end), .avg_all(avg_all), .stat_all(stat_all)
);

// File: tb/test_busmon_wm.sv
module test_busmon_wm;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0, irq;
  logic [1:0]  evt = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  busmon_wm i_busmon_wm (
    .clk(clk), .rst_n(rst_n), .tick_ms_i(tick), .evt_i(evt), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // event count per period, expected average, expected channel-0 status
  localparam int NV = 8;
  localparam int          VN  [NV] = '{6, 6, 3, 1, 10, 10, 5, 2};
  localparam logic [31:0] VAVG[NV] = '{12, 18, 15, 9, 24, 32, 26, 17};
  localparam logic [31:0] VST [NV] = '{32'h0, 32'h8000_0000, 32'h0, 32'h4000_0000,
                                       32'h0, 32'hA000_0000, 32'h0, 32'h0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic strobes(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt[ch] = 1'b1;
    end
    @(negedge clk); evt = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rreg(8'h00, v); chk("R1 glb status", v, 0);
    rreg(8'h04, v); chk("R1 period", v, 0);
    rreg(8'h40, v); chk("R1 ctrl0", v, 0);
    rreg(8'h60, v); chk("R1 avg0", v, 0);
    rreg(8'h5C, v); chk("R1 stat0", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // channel 0: weight 4, raw band 8..20, avg upper 30, K=0, above N=2, below N=1
    wreg(8'h44, 4); wreg(8'h48, 0); wreg(8'h4C, 20); wreg(8'h50, 8);
    wreg(8'h54, 30); wreg(8'h58, 0);
    wreg(8'h40, 32'hE424_0000);

    for (int i = 0; i < NV; i++) begin
      strobes(0, VN[i]);
      ticks(1);
      rreg(8'h60, v); chk("R4 average", v, VAVG[i]);
      rreg(8'h5C, v); chk("R6 R7 R8 status", v, VST[i]);
      chk("R10 irq", {31'd0, irq}, {31'd0, VST[i] != 0});
      rreg(8'h00, v); chk("R10 glb bit26", v, (VST[i] != 0) ? 32'h0400_0000 : 32'h0);
      if (VST[i] == 32'hA000_0000) begin
        wreg(8'h5C, 32'h2000_0000);
        rreg(8'h5C, v); chk("R9 partial clear", v, 32'h8000_0000);
      end
      wreg(8'h5C, 32'hFFFF_FFFF);
      rreg(8'h5C, v); chk("R9 full clear", v, 0);
    end

    // R11: inactive channel ignores strobes and period ends
    wreg(8'h40, 32'h0004_0000);
    strobes(0, 4);
    ticks(2);
    rreg(8'h60, v); chk("R11 avg held", v, 17);
    rreg(8'h5C, v); chk("R11 no status", v, 0);

    // channel 1: period of 3 ticks, weight 1, K=1, avg lower 80, init 100
    wreg(8'h04, 2);
    wreg(8'h84, 1); wreg(8'h88, 100); wreg(8'h8C, 1000); wreg(8'h90, 0);
    wreg(8'h94, 1000); wreg(8'h98, 80);
    wreg(8'h80, 32'h8014_0400);
    rreg(8'hA0, v); chk("R5 init load", v, 100);

    strobes(1, 8);
    ticks(2);
    rreg(8'hA0, v); chk("R3 no update before P+1 ticks", v, 100);
    ticks(1);
    rreg(8'hA0, v); chk("R3 R4 update K=1", v, 77);
    rreg(8'h9C, v); chk("R8 avg below", v, 32'h1000_0000);
    rreg(8'h00, v); chk("R10 glb bit25", v, 32'h0200_0000);
    chk("R10 irq ch1", {31'd0, irq}, 1);
    wreg(8'h9C, 32'hFFFF_FFFF);

    // R2: strobe coinciding with the closing tick goes to the next period
    ticks(2);
    @(negedge clk); tick = 1'b1; evt[1] = 1'b1;
    @(negedge clk); tick = 1'b0; evt = '0;
    rreg(8'hA0, v); chk("R2 closing period count zero", v, 57);
    ticks(3);
    rreg(8'hA0, v); chk("R2 strobe in next period", v, 43);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule